// File: doc/BRIEF.md
# ADC Scan Sequencer with Result Accumulation

This block runs one conversion scan per trigger for an analog-to-digital converter with eleven logical channels. A falling edge on the trigger input starts the scan. Channels are then converted one at a time from the highest number down to channel 0, so the signals a control loop needs most are measured last. Each channel writes its sample into a result slot chosen by configuration. Each slot can either keep a single sample or add up two or four samples before it reports a complete value. When two channels point at the same physical input and the same slot, one before and one after the instant of interest, the slot's sum stands for the value at that instant.

Channels 0 and 1 can read a different physical input through an alias setting. Every other action, including the sync request sent to a partner converter, still uses the channel's own number. Channels can also be marked for a band check; a sample that falls inside the band raises an event. A one-cycle completion pulse follows the last store of the scan and can start a data mover. Results are read through a simple read port, and reading a complete slot empties it. A behavioural converter model inside the block samples the selected input and returns the value after a fixed latency.

Top module: `adc_scan_seq`

## Requirements
- R1: A scan starts only on a 1-to-0 transition of `trig_in`; a trigger held steady at either level, or a 0-to-1 transition, starts nothing.
- R2: A scan converts every channel exactly once, in order from NCH-1 down to 0.
- R3: When channel 0 or 1 has its alias bit set, it samples physical input `cfg_alias_sel[ch*IW +: IW]` in place of its own number. All other behaviour, including `sync_chan`, keeps the original channel number.
- R4: Channel ch stores its sample into slot `cfg_res_sel[ch*RIW +: RIW]`. In single mode, when two channels share a slot, the later one (the lower channel number) is the value left in the slot.
- R5: Slot s takes its mode from `cfg_red_mode[2*s +: 2]`: code 1 sums 2 samples, code 3 sums 4 samples, codes 0 and 2 keep one sample. The slot reads as complete (`rd_valid`=1) only after its full count of samples; the sum is 14 bits wide.
- R6: A read (`rd_en` with `rd_idx`) returns the slot's value and completeness on the next cycle. Reading a complete slot clears it to zero. Reading an incomplete slot leaves it unchanged.
- R7: The start of each scan clears every slot to zero and marks it incomplete.
- R8: `sync_req` pulses in the conversion-start cycle of each channel whose `cfg_sync_en` bit is set, with `sync_chan` giving that channel's number. Channels whose bit is clear send no sync request.
- R9: For a channel with its `cfg_lim_en` bit set, a sample v with `cfg_lim_lo` <= v <= `cfg_lim_hi` gives a one-cycle `evt_valid` pulse, with `evt_chan` naming the channel. A sample outside the band gives none.
- R10: `scan_done` is a single-cycle pulse in the cycle after channel 0's store. Falling trigger edges seen while a scan runs are ignored.
- R11: After reset, `scan_done`, `sync_req`, `evt_valid` and `rd_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Scan trigger, active on its falling edge |
| ain | input | NIN*DW | Sample values of the physical inputs, DW bits each |
| cfg_res_sel | input | NCH*RIW | Result slot index per channel |
| cfg_red_mode | input | NRES*2 | Accumulation mode per slot |
| cfg_alias_en | input | NALIAS | Alias enable for channels 0 and 1 |
| cfg_alias_sel | input | NALIAS*IW | Substitute physical input per aliased channel |
| cfg_sync_en | input | NCH | Sync request enable per channel |
| cfg_lim_en | input | NCH | Band check enable per channel |
| cfg_lim_lo | input | DW | Lower band bound, inclusive |
| cfg_lim_hi | input | DW | Upper band bound, inclusive |
| rd_en | input | 1 | Read strobe |
| rd_idx | input | RIW | Slot to read |
| rd_data | output | AW | Value of the slot read |
| rd_valid | output | 1 | Slot read was complete |
| sync_req | output | 1 | Sync request to the partner converter |
| sync_chan | output | CHW | Channel number of the sync request |
| evt_valid | output | 1 | Band check event |
| evt_chan | output | CHW | Channel that raised the event |
| scan_done | output | 1 | Scan completion pulse |

## Verification
The bench uses the default parameters: eleven channels, sixteen inputs and slots, 12-bit samples, 14-bit sums and a four-cycle conversion. With sixteen slots, one scan can use a four-sample slot, a two-sample slot, a shared single slot and a short, incomplete four-sample slot all at once. With 14-bit sums, the all-ones input pattern reaches the largest two-sample sum without overflow. The bench also drives the trigger's edges and levels in the idle and busy states, and checks values that sit exactly on the band bounds.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SAMPLE,
        S_CONV,
        S_STORE,
        S_DONE
    } seq_state_t;

    localparam logic [1:0] RED_SUM2 = 2'd1;
    localparam logic [1:0] RED_SUM4 = 2'd3;

endpackage

// File: rtl/adc_conv_stub.sv
module adc_conv_stub #(
    parameter int NIN         = 16,
    parameter int DW          = 12,
    parameter int CONV_CYCLES = 4,
    localparam int IW         = $clog2(NIN),
    localparam int CW         = $clog2(CONV_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IW-1:0]     sel,
    input  logic [NIN*DW-1:0] ain,
    output logic              done,
    output logic [DW-1:0]     value
);

    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic          done_q;
    logic [DW-1:0] value_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            value_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                value_q <= ain[int'(sel)*DW +: DW];
                cnt_q   <= CW'(CONV_CYCLES);
                busy_q  <= 1'b1;
            end else if (busy_q) begin
                if (cnt_q == CW'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CW'(1);
                end
            end
        end
    end

    assign done  = done_q;
    assign value = value_q;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int NCH    = 11,
    parameter int NIN    = 16,
    parameter int NALIAS = 2,
    localparam int CHW   = $clog2(NCH),
    localparam int IW    = $clog2(NIN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_fall,
    input  logic                 conv_done,
    input  logic [NALIAS-1:0]    alias_en,
    input  logic [NALIAS*IW-1:0] alias_sel,
    input  logic [NCH-1:0]       sync_en,
    output logic                 scan_start,
    output logic                 conv_start,
    output logic [IW-1:0]        phys_sel,
    output logic [CHW-1:0]       cur_ch,
    output logic                 store,
    output logic                 scan_done,
    output logic                 sync_req,
    output logic [CHW-1:0]       sync_chan
);

    seq_state_t     state_q, state_d;
    logic [CHW-1:0] ch_q;

    // State register and channel counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ch_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && trig_fall) begin
                ch_q <= CHW'(NCH - 1);
            end else if (state_q == S_STORE && ch_q != '0) begin
                ch_q <= ch_q - CHW'(1);
            end
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (trig_fall) state_d = S_SAMPLE;
            S_SAMPLE: state_d = S_CONV;
            S_CONV:   if (conv_done) state_d = S_STORE;
            S_STORE:  state_d = (ch_q == '0) ? S_DONE : S_SAMPLE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        scan_start = 1'b0;
        conv_start = 1'b0;
        store      = 1'b0;
        scan_done  = 1'b0;
        sync_req   = 1'b0;
        unique case (state_q)
            S_IDLE:   scan_start = trig_fall;
            S_SAMPLE: begin
                conv_start = 1'b1;
                sync_req   = sync_en[ch_q];
            end
            S_CONV:   ;
            S_STORE:  store = 1'b1;
            S_DONE:   scan_done = 1'b1;
            default:  ;
        endcase
    end

    // Physical input selection with alias substitution
    always_comb begin
        phys_sel = IW'(ch_q);
        for (int a = 0; a < NALIAS; a++) begin
            if (ch_q == CHW'(a) && alias_en[a]) begin
                phys_sel = alias_sel[a*IW +: IW];
            end
        end
    end

    assign cur_ch    = ch_q;
    assign sync_chan = ch_q;

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
    import adc_seq_pkg::*;
#(
    parameter int NRES = 16,
    parameter int DW   = 12,
    parameter int AW   = 14,
    localparam int RIW = $clog2(NRES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_all,
    input  logic              wr_en,
    input  logic [RIW-1:0]    wr_idx,
    input  logic [DW-1:0]     wr_val,
    input  logic [NRES*2-1:0] red_mode,
    input  logic              rd_en,
    input  logic [RIW-1:0]    rd_idx,
    output logic [AW-1:0]     rd_data,
    output logic              rd_valid
);

    logic [AW-1:0] acc_q [NRES];
    logic [AW-1:0] acc_d [NRES];
    logic [2:0]    cnt_q [NRES];
    logic [2:0]    cnt_d [NRES];
    logic [NRES-1:0] full_q, full_d;
    logic [AW-1:0] rd_data_q;
    logic          rd_valid_q;

    function automatic logic [2:0] addends(input logic [1:0] mode);
        case (mode)
            RED_SUM2: addends = 3'd2;
            RED_SUM4: addends = 3'd4;
            default:  addends = 3'd1;
        endcase
    endfunction

    always_comb begin
        for (int i = 0; i < NRES; i++) begin
            acc_d[i]  = acc_q[i];
            cnt_d[i]  = cnt_q[i];
            full_d[i] = full_q[i];
            if (clr_all) begin
                acc_d[i]  = '0;
                cnt_d[i]  = '0;
                full_d[i] = 1'b0;
            end else if (wr_en && wr_idx == RIW'(i)) begin
                acc_d[i]  = (full_q[i] ? '0 : acc_q[i]) + AW'(wr_val);
                cnt_d[i]  = (full_q[i] ? 3'd0 : cnt_q[i]) + 3'd1;
                full_d[i] = (cnt_d[i] == addends(red_mode[2*i +: 2]));
            end else if (rd_en && rd_idx == RIW'(i) && full_q[i]) begin
                acc_d[i]  = '0;
                cnt_d[i]  = '0;
                full_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NRES; i++) begin
                acc_q[i] <= '0;
                cnt_q[i] <= '0;
            end
            full_q     <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            for (int i = 0; i < NRES; i++) begin
                acc_q[i] <= acc_d[i];
                cnt_q[i] <= cnt_d[i];
            end
            full_q <= full_d;
            if (rd_en) begin
                rd_data_q  <= acc_q[rd_idx];
                rd_valid_q <= full_q[rd_idx];
            end
        end
    end

    assign rd_data  = rd_data_q;
    assign rd_valid = rd_valid_q;

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int NCH         = 11,
    parameter int NIN         = 16,
    parameter int NRES        = 16,
    parameter int DW          = 12,
    parameter int AW          = 14,
    parameter int NALIAS      = 2,
    parameter int CONV_CYCLES = 4,
    localparam int CHW        = $clog2(NCH),
    localparam int IW         = $clog2(NIN),
    localparam int RIW        = $clog2(NRES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 trig_in,
    input  logic [NIN*DW-1:0]    ain,
    input  logic [NCH*RIW-1:0]   cfg_res_sel,
    input  logic [NRES*2-1:0]    cfg_red_mode,
    input  logic [NALIAS-1:0]    cfg_alias_en,
    input  logic [NALIAS*IW-1:0] cfg_alias_sel,
    input  logic [NCH-1:0]       cfg_sync_en,
    input  logic [NCH-1:0]       cfg_lim_en,
    input  logic [DW-1:0]        cfg_lim_lo,
    input  logic [DW-1:0]        cfg_lim_hi,
    input  logic                 rd_en,
    input  logic [RIW-1:0]       rd_idx,
    output logic [AW-1:0]        rd_data,
    output logic                 rd_valid,
    output logic                 sync_req,
    output logic [CHW-1:0]       sync_chan,
    output logic                 evt_valid,
    output logic [CHW-1:0]       evt_chan,
    output logic                 scan_done
);

    logic           trig_q;
    logic           trig_fall;
    logic           scan_start;
    logic           conv_start;
    logic           conv_done;
    logic [IW-1:0]  phys_sel;
    logic [CHW-1:0] cur_ch;
    logic           store;
    logic [DW-1:0]  conv_val;
    logic [RIW-1:0] wr_idx;
    logic           evt_q;
    logic [CHW-1:0] evt_ch_q;

    // Trigger edge detector
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b1;
        else        trig_q <= trig_in;
    end
    assign trig_fall = trig_q & ~trig_in;

    adc_seq_fsm #(
        .NCH    (NCH),
        .NIN    (NIN),
        .NALIAS (NALIAS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_fall  (trig_fall),
        .conv_done  (conv_done),
        .alias_en   (cfg_alias_en),
        .alias_sel  (cfg_alias_sel),
        .sync_en    (cfg_sync_en),
        .scan_start (scan_start),
        .conv_start (conv_start),
        .phys_sel   (phys_sel),
        .cur_ch     (cur_ch),
        .store      (store),
        .scan_done  (scan_done),
        .sync_req   (sync_req),
        .sync_chan  (sync_chan)
    );

    adc_conv_stub #(
        .NIN         (NIN),
        .DW          (DW),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_conv (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .sel   (phys_sel),
        .ain   (ain),
        .done  (conv_done),
        .value (conv_val)
    );

    assign wr_idx = cfg_res_sel[int'(cur_ch)*RIW +: RIW];

    adc_result_bank #(
        .NRES (NRES),
        .DW   (DW),
        .AW   (AW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (scan_start),
        .wr_en    (store),
        .wr_idx   (wr_idx),
        .wr_val   (conv_val),
        .red_mode (cfg_red_mode),
        .rd_en    (rd_en),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Band check on each stored sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q    <= 1'b0;
            evt_ch_q <= '0;
        end else begin
            evt_q    <= store && cfg_lim_en[cur_ch] &&
                        (conv_val >= cfg_lim_lo) && (conv_val <= cfg_lim_hi);
            evt_ch_q <= cur_ch;
        end
    end

    assign evt_valid = evt_q;
    assign evt_chan  = evt_ch_q;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
    parameter int NCH  = 11,
    localparam int CHW = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           store,
    input logic [CHW-1:0] cur_ch,
    input logic           scan_done,
    input logic           sync_req,
    input logic [CHW-1:0] sync_chan,
    input logic           evt_valid,
    input logic [CHW-1:0] evt_chan
);

    logic           have_q;
    logic [CHW-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_q <= 1'b0;
            last_q <= '0;
        end else if (scan_done) begin
            have_q <= 1'b0;
        end else if (store) begin
            have_q <= 1'b1;
            last_q <= cur_ch;
        end
    end

    a_r2_descending: assert property (@(posedge clk) disable iff (!rst_n)
        store && have_q |-> cur_ch == last_q - CHW'(1));

    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);

    a_r10_done_after_ch0: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> $past(store) && $past(cur_ch) == '0);

    a_r8_sync_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |-> int'(sync_chan) < NCH && !store);

    a_r9_evt_follows_store: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(store) && evt_chan == $past(cur_ch));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .store     (store),
    .cur_ch    (cur_ch),
    .scan_done (scan_done),
    .sync_req  (sync_req),
    .sync_chan (sync_chan),
    .evt_valid (evt_valid),
    .evt_chan  (evt_chan)
);

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;

    localparam int NCH = 11, NIN = 16, NRES = 16, DW = 12, AW = 14, NALIAS = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_in = 1'b1;
    logic [NIN*DW-1:0]  ain;
    logic [NCH*4-1:0]   cfg_res_sel;
    logic [NRES*2-1:0]  cfg_red_mode;
    logic [NALIAS-1:0]  cfg_alias_en;
    logic [NALIAS*4-1:0] cfg_alias_sel;
    logic [NCH-1:0]     cfg_sync_en = '0;
    logic [NCH-1:0]     cfg_lim_en = '0;
    logic [DW-1:0]      cfg_lim_lo = '0, cfg_lim_hi = '0;
    logic               rd_en = 1'b0;
    logic [3:0]         rd_idx = '0;
    logic [AW-1:0]      rd_data;
    logic               rd_valid, sync_req, evt_valid, scan_done;
    logic [3:0]         sync_chan, evt_chan;

    logic [11:0] b_ain [NIN];
    logic [3:0]  b_res [NCH];
    logic [1:0]  b_red [NRES];
    logic        b_aen [NALIAS];
    logic [3:0]  b_asel [NALIAS];

    always_comb begin
        for (int i = 0; i < NIN; i++)    ain[i*DW +: DW] = b_ain[i];
        for (int i = 0; i < NCH; i++)    cfg_res_sel[i*4 +: 4] = b_res[i];
        for (int i = 0; i < NRES; i++)   cfg_red_mode[i*2 +: 2] = b_red[i];
        for (int i = 0; i < NALIAS; i++) begin
            cfg_alias_en[i] = b_aen[i];
            cfg_alias_sel[i*4 +: 4] = b_asel[i];
        end
    end

    adc_scan_seq dut (.*);

    always #4 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int done_n = 0, sync_n = 0, evt_n = 0;
    logic [3:0] sync_log [32];
    logic [3:0] evt_log [32];

    always @(negedge clk) if (rst_n) begin
        if (scan_done) done_n++;
        if (sync_req) begin
            if (sync_n < 32) sync_log[sync_n] = sync_chan;
            sync_n++;
        end
        if (evt_valid) begin
            if (evt_n < 32) evt_log[evt_n] = evt_chan;
            evt_n++;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    task automatic pulse_trig();
        @(negedge clk) trig_in = 1'b0;
        repeat (2) @(negedge clk);
        trig_in = 1'b1;
    endtask

    task automatic wait_done();
        int start = done_n;
        for (int k = 0; k < 1000 && done_n == start; k++) @(negedge clk);
        check("R10 scan completes", 32'(done_n - start), 32'd1);
    endtask

    task automatic read_slot(input int idx, output logic [AW-1:0] d, output logic v);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = 4'(idx);
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    // Expected slot contents after one scan, built from R3, R4, R5 and R7
    logic [AW-1:0] e_acc [NRES];
    logic [2:0]    e_cnt [NRES];
    logic          e_full [NRES];

    task automatic model_scan();
        for (int s = 0; s < NRES; s++) begin
            e_acc[s] = '0; e_cnt[s] = '0; e_full[s] = 1'b0;
        end
        for (int ch = NCH - 1; ch >= 0; ch--) begin
            int phys = ch;
            int s = int'(b_res[ch]);
            int need = (b_red[s] == 2'd1) ? 2 : (b_red[s] == 2'd3) ? 4 : 1;
            if (ch < NALIAS && b_aen[ch]) phys = int'(b_asel[ch]);
            if (e_full[s]) begin
                e_acc[s] = '0; e_cnt[s] = '0; e_full[s] = 1'b0;
            end
            e_acc[s] = e_acc[s] + AW'(b_ain[phys]);
            e_cnt[s] = e_cnt[s] + 3'd1;
            e_full[s] = (int'(e_cnt[s]) == need);
        end
    endtask

    // Stimulus table: input value base and step per input
    localparam logic [23:0] VEC [4] = '{
        {12'h100, 12'h011},
        {12'hFFF, 12'h000},
        {12'h000, 12'h123},
        {12'h800, 12'h0F0}
    };

    initial begin
        logic [AW-1:0] d;
        logic v;
        int base_d, base_e;

        // Configuration A: ch4 and aliased ch0 share slot 0, ch3 and aliased ch1 share slot 1
        for (int i = 0; i < NIN; i++)  b_ain[i] = '0;
        for (int i = 0; i < NCH; i++)  b_res[i] = 4'(i);
        for (int i = 0; i < NRES; i++) b_red[i] = 2'd0;
        b_res[4] = 4'd0; b_res[3] = 4'd1;
        b_red[0] = 2'd1; b_red[1] = 2'd1;
        b_aen[0] = 1'b1; b_asel[0] = 4'd4;
        b_aen[1] = 1'b1; b_asel[1] = 4'd3;
        cfg_sync_en = '1;

        repeat (3) @(negedge clk);
        check("R11 scan_done at reset", 32'(scan_done), 0);
        check("R11 sync_req at reset", 32'(sync_req), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 evt_valid after reset", 32'(evt_valid), 0);
        read_slot(0, d, v);
        check("R11 rd_valid after reset", 32'(v), 0);

        // Table walk: R3 R4 R5 over several input patterns
        for (int t = 0; t < 4; t++) begin
            for (int i = 0; i < NIN; i++) b_ain[i] = VEC[t][23:12] + 12'(i) * VEC[t][11:0];
            sync_n = 0;
            pulse_trig();
            wait_done();
            model_scan();
            if (t == 0) begin
                check("R2 one sync per channel", 32'(sync_n), 32'(NCH));
                for (int k = 0; k < NCH; k++)
                    check("R2 R3 sync_chan order", 32'(sync_log[k]), 32'(NCH - 1 - k));
            end
            for (int s = 0; s < NRES; s++) begin
                read_slot(s, d, v);
                check("R4 R5 slot data", 32'(d), 32'(e_acc[s]));
                check("R5 slot complete", 32'(v), 32'(e_full[s]));
            end
        end
        check("R9 no event when disabled", 32'(evt_n), 0);

        // R1: steady levels and a rising edge start nothing
        base_d = done_n;
        repeat (150) @(negedge clk);
        check("R1 high level idle", 32'(done_n - base_d), 0);
        @(negedge clk) trig_in = 1'b0;
        repeat (150) @(negedge clk);
        check("R1 falling edge one scan", 32'(done_n - base_d), 1);
        trig_in = 1'b1;
        repeat (150) @(negedge clk);
        check("R1 rising edge ignored", 32'(done_n - base_d), 1);

        // R10: trigger during a running scan is ignored
        base_d = done_n;
        pulse_trig();
        repeat (20) @(negedge clk);
        pulse_trig();
        repeat (300) @(negedge clk);
        check("R10 busy trigger ignored", 32'(done_n - base_d), 1);

        // Configuration B: sum-4, short sum-4, shared single, sum-2, sparse sync, band check
        for (int i = 0; i < NIN; i++) b_ain[i] = 12'(i << 8);
        b_aen[0] = 1'b0; b_aen[1] = 1'b0;
        b_res[8] = 4'd12; b_res[7] = 4'd12; b_res[6] = 4'd12; b_res[5] = 4'd12;
        b_res[10] = 4'd13; b_res[9] = 4'd13; b_res[2] = 4'd13;
        b_res[4] = 4'd14; b_res[3] = 4'd14;
        b_res[1] = 4'd15; b_res[0] = 4'd15;
        b_red[12] = 2'd3; b_red[13] = 2'd3; b_red[14] = 2'd0; b_red[15] = 2'd1;
        cfg_sync_en = '0; cfg_sync_en[5] = 1'b1; cfg_sync_en[0] = 1'b1;
        cfg_lim_en = '0; cfg_lim_en[10] = 1'b1; cfg_lim_en[9] = 1'b1;
        cfg_lim_lo = 12'hA00; cfg_lim_hi = 12'hA80;
        sync_n = 0; base_e = evt_n;
        pulse_trig();
        wait_done();
        check("R8 sync count", 32'(sync_n), 2);
        check("R8 first sync chan", 32'(sync_log[0]), 5);
        check("R8 second sync chan", 32'(sync_log[1]), 0);
        check("R9 event count", 32'(evt_n - base_e), 1);
        check("R9 event chan", 32'(evt_log[base_e]), 10);

        read_slot(12, d, v);
        check("R5 sum of four", 32'(d), 32'h1A00);
        check("R5 sum of four complete", 32'(v), 1);
        read_slot(13, d, v);
        check("R5 three of four partial", 32'(d), 32'h1500);
        check("R5 three of four incomplete", 32'(v), 0);
        read_slot(14, d, v);
        check("R4 shared single last wins", 32'(d), 32'h300);
        read_slot(15, d, v);
        check("R5 sum of two", 32'(d), 32'h100);
        check("R5 sum of two complete", 32'(v), 1);

        read_slot(12, d, v);
        check("R6 complete read clears data", 32'(d), 0);
        check("R6 complete read clears flag", 32'(v), 0);
        read_slot(13, d, v);
        check("R6 incomplete read keeps data", 32'(d), 32'h1500);

        // R9 upper bound inclusive
        cfg_lim_lo = 12'h900; cfg_lim_hi = 12'h900;
        base_e = evt_n;
        pulse_trig();
        wait_done();
        check("R9 upper bound event count", 32'(evt_n - base_e), 1);
        check("R9 upper bound event chan", 32'(evt_log[base_e]), 9);

        // R7: slot left partial is cleared by the next scan start
        read_slot(13, d, v);
        check("R7 partial before rescan", 32'(d), 32'h1500);
        b_res[10] = 4'd11; b_res[9] = 4'd11; b_res[2] = 4'd11;
        pulse_trig();
        wait_done();
        read_slot(13, d, v);
        check("R7 slot cleared by scan start", 32'(d), 0);
        check("R7 slot flag cleared", 32'(v), 0);
        read_slot(11, d, v);
        check("R4 later channel value", 32'(d), 32'h200);

        summary();
    end

endmodule